// File: doc/BRIEF.md
# Cache Line Error Retirement Controller

This block holds the data array of a small set-associative cache, with every word stored as a SECDED codeword, and decides at run time which lines to take out of service. Each read is decoded. A single-bit error is corrected on the same access and counted against the line. When a line's count of corrected errors reaches a programmable threshold, or when a read finds an uncorrectable error, the line is purged and marked deleted. The allocator never hands out a deleted line again, and no reset is needed for any of this.

A purged line that held clean data costs nothing: the requester sees a miss and refetches from memory. A dirty line that hits an uncorrectable error returns its data with a poison flag, so the loss is reported instead of dropped. Every correction and every retirement raises a one-cycle event that carries the set, the way and the kind of event. Two fault-injection masks are XORed into the codeword, one at allocation (a stored fault) and one on the read path (a transient upset). They let the error handling be exercised.

Top module: `line_retire_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, there is no read response and no event. All lines start invalid and not deleted, so the first allocations to a set take ways 0, 1, 2, 3 in that order.
- R2: A read whose codeword has exactly one flipped bit, at any of the codeword positions, returns the original data as a hit. It raises an event of type 1 (corrected) with the set and way that were read.
- R3: After a corrected read of a line that is not retired, the corrected codeword is written back. A later read of a stored single-bit fault, with no new upset, returns the data with no event.
- R4: Each line counts its corrected errors. When the count, including the current error, reaches `thresh_i`, the line is retired: the corrected data is still returned as a hit, an event of type 2 (retired, no loss) is raised, and the line is deleted. A change to `thresh_i` takes effect on the next read.
- R5: A read with two flipped bits on a clean line returns a miss with the poison flag low, raises an event of type 2, and deletes the line.
- R6: A read with two flipped bits on a dirty line returns `rd_poison_o`=1 with `rd_miss_o`=0, raises an event of type 3 (retired, poisoned data), and deletes the line.
- R7: Allocation never picks a deleted way. It takes the lowest-numbered way that is invalid and not deleted. If there is none, it takes the first way that is not deleted, scanning upward with wrap from a per-set pointer, and then moves the pointer to the way after the victim.
- R8: When every way of the requested set is deleted, `alloc_ok_o` is 0, `set_exhausted_o` is 1 and nothing is written.
- R9: Allocating a line clears its error count. A line that had corrected errors before reallocation is not retired early afterwards.
- R10: A read of a line that is invalid or deleted returns a miss with no event.
- R11: The read response and the event appear exactly one cycle after the read request. The event is a single-cycle pulse for each read that raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all line state, including the deleted bitmap |
| thresh_i | input | CNT_W | Corrected-error count that retires a line |
| rd_valid_i | input | 1 | Read request |
| rd_set_i | input | SET_W | Set to read |
| rd_way_i | input | WAY_W | Way to read (hit way from the tag lookup) |
| rd_flip_i | input | CW | Upset mask XORed into the codeword on the read path |
| rd_resp_valid_o | output | 1 | Read response valid, one cycle after the request |
| rd_miss_o | output | 1 | Response is a miss; the requester refetches |
| rd_poison_o | output | 1 | Response data is uncorrectable dirty data |
| rd_data_o | output | DATA_W | Response data (corrected when correctable) |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_set_i | input | SET_W | Set to allocate into |
| alloc_data_i | input | DATA_W | Fill data |
| alloc_dirty_i | input | 1 | Fill is dirty |
| alloc_flip_i | input | CW | Fault mask XORed into the stored codeword |
| alloc_ok_o | output | 1 | A way was allocated |
| alloc_way_o | output | WAY_W | Allocated way |
| set_exhausted_o | output | 1 | Every way of the set is deleted; the access is uncacheable |
| ev_valid_o | output | 1 | Error event pulse |
| ev_set_o | output | SET_W | Set of the event |
| ev_way_o | output | WAY_W | Way of the event |
| ev_type_o | output | 2 | 1 corrected, 2 retired without loss, 3 retired with poison |

## Verification
The bench drives the threshold crossing at exactly the third corrected error on one line and checks that the first two only correct. A counter that is off by one would retire a read early or late. It reallocates a line that already has corrected errors, which catches a count that survives allocation. It deletes a way that sits at the victim pointer, and then every way of a set, so a picker that ignores the deleted bitmap would hand out a dead way and an exhausted set would still report a grant. Uncorrectable errors on clean and on dirty lines are compared for miss versus poison. A read with no new upset after a stored single-bit fault shows whether the write-back took place.

// File: rtl/line_retire_pkg.sv
package line_retire_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_CORR   = 2'd1,
    EV_RETIRE = 2'd2,
    EV_POISON = 2'd3
  } ev_kind_e;

  // smallest Hamming check-bit count for dw data bits
  function automatic int secded_pbits(input int dw);
    for (int p = 1; p < 31; p++) begin
      if ((1 << p) >= dw + p + 1) return p;
    end
    return 31;
  endfunction

  function automatic int secded_cw(input int dw);
    return dw + secded_pbits(dw) + 1;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import line_retire_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int P = secded_pbits(DATA_W),
  localparam int CW = DATA_W + P + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW-1:0]     cw_o
);
  // bit 0: overall parity, bit 2^j: check bit j, others: data
  always_comb begin
    int  d;
    logic par;
    cw_o = '0;
    d    = 0;
    par  = 1'b0;
    for (int k = 1; k < CW; k++) begin
      if ((k & (k - 1)) != 0) begin
        cw_o[k] = data_i[d];
        d++;
      end
    end
    for (int j = 0; j < P; j++) begin
      par = 1'b0;
      for (int k = 1; k < CW; k++) begin
        if (k[j]) par = par ^ cw_o[k];
      end
      cw_o[1 << j] = par;
    end
    cw_o[0] = ^cw_o[CW-1:1];
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import line_retire_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int P = secded_pbits(DATA_W),
  localparam int CW = DATA_W + P + 1
) (
  input  logic [CW-1:0]     cw_i,
  output logic [CW-1:0]     fix_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ce_o,
  output logic              ue_o
);
  always_comb begin
    logic [P-1:0] syn;
    logic         ovr;
    int           d;
    syn = '0;
    for (int k = 1; k < CW; k++) begin
      if (cw_i[k]) syn = syn ^ P'(k);
    end
    ovr  = ^cw_i;
    ce_o = 1'b0;
    ue_o = 1'b0;
    if (ovr) begin
      if (int'(syn) < CW) ce_o = 1'b1;
      else                ue_o = 1'b1;
    end else if (syn != '0) begin
      ue_o = 1'b1;
    end
    fix_o = cw_i;
    for (int k = 0; k < CW; k++) begin
      if (ce_o && (P'(k) == syn)) fix_o[k] = ~cw_i[k];
    end
    d      = 0;
    data_o = '0;
    for (int k = 1; k < CW; k++) begin
      if ((k & (k - 1)) != 0) begin
        data_o[d] = fix_o[k];
        d++;
      end
    end
  end
endmodule

// File: rtl/retire_way_pick.sv
module retire_way_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  del_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic             ok_o,
  output logic             victim_o,
  output logic [WAY_W-1:0] way_o
);
  always_comb begin
    int idx;
    idx      = 0;
    ok_o     = 1'b0;
    victim_o = 1'b0;
    way_o    = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!ok_o && !valid_i[i] && !del_i[i]) begin
        ok_o  = 1'b1;
        way_o = WAY_W'(i);
      end
    end
    if (!ok_o) begin
      for (int i = 0; i < WAYS; i++) begin
        idx = (int'(ptr_i) + i) % WAYS;
        if (!ok_o && !del_i[idx]) begin
          ok_o     = 1'b1;
          victim_o = 1'b1;
          way_o    = WAY_W'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/line_retire_ctrl.sv
module line_retire_ctrl
  import line_retire_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CW    = secded_cw(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic              rd_valid_i,
  input  logic [SET_W-1:0]  rd_set_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [CW-1:0]     rd_flip_i,
  output logic              rd_resp_valid_o,
  output logic              rd_miss_o,
  output logic              rd_poison_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              alloc_valid_i,
  input  logic [SET_W-1:0]  alloc_set_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  input  logic              alloc_dirty_i,
  input  logic [CW-1:0]     alloc_flip_i,
  output logic              alloc_ok_o,
  output logic [WAY_W-1:0]  alloc_way_o,
  output logic              set_exhausted_o,
  output logic              ev_valid_o,
  output logic [SET_W-1:0]  ev_set_o,
  output logic [WAY_W-1:0]  ev_way_o,
  output logic [1:0]        ev_type_o
);
  localparam int LINES  = SETS * WAYS;
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CW-1:0]    mem_q [LINES];
  logic [CNT_W-1:0] cnt_q [LINES];
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [LINES-1:0] valid_q, dirty_q, del_q;

  // read path
  logic [LINE_W-1:0] rd_line;
  logic [CW-1:0]     rd_cw, rd_fix;
  logic [DATA_W-1:0] rd_dec;
  logic              rd_ce, rd_ue, rd_hit, ce_retire;
  logic [CNT_W-1:0]  cnt_nx;

  assign rd_line = LINE_W'(int'(rd_set_i) * WAYS + int'(rd_way_i));
  assign rd_cw   = mem_q[rd_line] ^ rd_flip_i;
  assign rd_hit  = valid_q[rd_line];
  assign cnt_nx  = (cnt_q[rd_line] == CNT_MAX) ? CNT_MAX : cnt_q[rd_line] + 1'b1;
  assign ce_retire = cnt_nx >= thresh_i;

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .cw_i  (rd_cw),
    .fix_o (rd_fix),
    .data_o(rd_dec),
    .ce_o  (rd_ce),
    .ue_o  (rd_ue)
  );

  // allocation path
  logic [WAYS-1:0]   set_valid, set_del;
  logic              pick_ok, pick_victim;
  logic [WAY_W-1:0]  pick_way;
  logic [LINE_W-1:0] al_line;
  logic [CW-1:0]     al_cw;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w] = valid_q[int'(alloc_set_i) * WAYS + w];
      set_del[w]   = del_q[int'(alloc_set_i) * WAYS + w];
    end
  end

  retire_way_pick #(.WAYS(WAYS)) u_pick (
    .valid_i (set_valid),
    .del_i   (set_del),
    .ptr_i   (ptr_q[alloc_set_i]),
    .ok_o    (pick_ok),
    .victim_o(pick_victim),
    .way_o   (pick_way)
  );

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i(alloc_data_i),
    .cw_o  (al_cw)
  );

  assign al_line         = LINE_W'(int'(alloc_set_i) * WAYS + int'(pick_way));
  assign alloc_ok_o      = alloc_valid_i && pick_ok;
  assign alloc_way_o     = pick_way;
  assign set_exhausted_o = alloc_valid_i && !pick_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        mem_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      valid_q         <= '0;
      dirty_q         <= '0;
      del_q           <= '0;
      rd_resp_valid_o <= 1'b0;
      rd_miss_o       <= 1'b0;
      rd_poison_o     <= 1'b0;
      rd_data_o       <= '0;
      ev_valid_o      <= 1'b0;
      ev_set_o        <= '0;
      ev_way_o        <= '0;
      ev_type_o       <= EV_NONE;
    end else begin
      rd_resp_valid_o <= rd_valid_i;
      rd_miss_o       <= 1'b0;
      rd_poison_o     <= 1'b0;
      rd_data_o       <= rd_hit ? rd_dec : '0;
      ev_valid_o      <= 1'b0;
      ev_set_o        <= rd_set_i;
      ev_way_o        <= rd_way_i;
      ev_type_o       <= EV_NONE;
      if (rd_valid_i) begin
        if (!rd_hit) begin
          rd_miss_o <= 1'b1;
        end else if (rd_ue) begin
          valid_q[rd_line] <= 1'b0;
          del_q[rd_line]   <= 1'b1;
          ev_valid_o       <= 1'b1;
          if (dirty_q[rd_line]) begin
            rd_poison_o <= 1'b1;
            ev_type_o   <= EV_POISON;
          end else begin
            rd_miss_o <= 1'b1;
            ev_type_o <= EV_RETIRE;
          end
        end else if (rd_ce) begin
          ev_valid_o <= 1'b1;
          if (ce_retire) begin
            valid_q[rd_line] <= 1'b0;
            del_q[rd_line]   <= 1'b1;
            ev_type_o        <= EV_RETIRE;
          end else begin
            cnt_q[rd_line] <= cnt_nx;
            mem_q[rd_line] <= rd_fix;
            ev_type_o      <= EV_CORR;
          end
        end
      end
      if (alloc_ok_o) begin
        mem_q[al_line]   <= al_cw ^ alloc_flip_i;
        cnt_q[al_line]   <= '0;
        valid_q[al_line] <= 1'b1;
        dirty_q[al_line] <= alloc_dirty_i;
        if (pick_victim) begin
          ptr_q[alloc_set_i] <= (int'(pick_way) == WAYS - 1) ? '0 : pick_way + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/line_retire_chk.sv
module line_retire_chk #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LINES = SETS * WAYS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_i,
  input logic              rd_resp_valid_o,
  input logic              rd_miss_o,
  input logic              rd_poison_o,
  input logic              alloc_ok_o,
  input logic [SET_W-1:0]  alloc_set_i,
  input logic [WAY_W-1:0]  alloc_way_o,
  input logic              set_exhausted_o,
  input logic              ev_valid_o,
  input logic [1:0]        ev_type_o,
  input logic [LINES-1:0]  del_q
);
  logic al_dead;
  assign al_dead = del_q[int'(alloc_set_i) * WAYS + int'(alloc_way_o)];

  a_r7_alloc_skips_deleted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok_o |-> !al_dead);
  a_r8_exhausted_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_exhausted_o |-> !alloc_ok_o);
  a_r4_delete_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((del_q & $past(del_q)) == $past(del_q)));
  a_r11_event_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> $past(rd_valid_i));
  a_r6_poison_has_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_poison_o |-> (ev_valid_o && ev_type_o == 2'd3));
  a_r10_miss_not_poison: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_resp_valid_o |-> !(rd_miss_o && rd_poison_o));
  a_r2_event_typed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> (ev_type_o != 2'd0));
endmodule

bind line_retire_ctrl line_retire_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_valid_i     (rd_valid_i),
  .rd_resp_valid_o(rd_resp_valid_o),
  .rd_miss_o      (rd_miss_o),
  .rd_poison_o    (rd_poison_o),
  .alloc_ok_o     (alloc_ok_o),
  .alloc_set_i    (alloc_set_i),
  .alloc_way_o    (alloc_way_o),
  .set_exhausted_o(set_exhausted_o),
  .ev_valid_o     (ev_valid_o),
  .ev_type_o      (ev_type_o),
  .del_q          (del_q)
);

// File: tb/tb_line_retire_ctrl.sv
module tb_line_retire_ctrl;
  import line_retire_pkg::*;
  localparam int SETS = 4, WAYS = 4, DW = 32;
  localparam int CW = secded_cw(DW);
  localparam int LINES = SETS * WAYS;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] thresh_i = 4'd3;
  logic rd_valid_i = 0, alloc_valid_i = 0, alloc_dirty_i = 0;
  logic [1:0] rd_set_i = 0, rd_way_i = 0, alloc_set_i = 0;
  logic [CW-1:0] rd_flip_i = '0, alloc_flip_i = '0;
  logic [DW-1:0] alloc_data_i = '0;
  logic rd_resp_valid_o, rd_miss_o, rd_poison_o, alloc_ok_o, set_exhausted_o, ev_valid_o;
  logic [DW-1:0] rd_data_o;
  logic [1:0] alloc_way_o, ev_set_o, ev_way_o, ev_type_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  line_retire_ctrl #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DW), .CNT_W(4)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  bit mv[LINES], md[LINES], mdel[LINES];
  int mcnt[LINES];
  int mptr[SETS];
  logic [CW-1:0] mmask[LINES];
  logic [DW-1:0] mdat[LINES];

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit rv, int rs, int rw, logic [CW-1:0] rf,
                      bit av, int as, logic [DW-1:0] ad, bit adirty, logic [CW-1:0] af);
    bit eok, evic, ehit, emiss, epois, eev;
    int eway, etype, ln, nerr, c;
    logic [DW-1:0] edat;
    rd_valid_i = rv; rd_set_i = 2'(rs); rd_way_i = 2'(rw); rd_flip_i = rf;
    alloc_valid_i = av; alloc_set_i = 2'(as); alloc_data_i = ad;
    alloc_dirty_i = adirty; alloc_flip_i = af;
    #1;
    eok = 0; evic = 0; eway = 0;
    if (av) begin
      for (int w = 0; w < WAYS; w++)
        if (!eok && !mv[as*WAYS+w] && !mdel[as*WAYS+w]) begin eok = 1; eway = w; end
      if (!eok)
        for (int i = 0; i < WAYS; i++) begin
          int x = (mptr[as] + i) % WAYS;
          if (!eok && !mdel[as*WAYS+x]) begin eok = 1; evic = 1; eway = x; end
        end
    end
    check(tag, "alloc_ok", alloc_ok_o, eok);
    check(tag, "set_exhausted", set_exhausted_o, av && !eok);
    if (eok) check(tag, "alloc_way", alloc_way_o, eway);
    // read model
    ehit = 0; emiss = 0; epois = 0; eev = 0; etype = 0; edat = '0;
    if (rv) begin
      ln = rs * WAYS + rw;
      if (!mv[ln]) emiss = 1;
      else begin
        nerr = $countones(mmask[ln] ^ rf);
        if (nerr == 0) begin ehit = 1; edat = mdat[ln]; end
        else if (nerr == 1) begin
          ehit = 1; edat = mdat[ln]; eev = 1;
          c = (mcnt[ln] >= 15) ? 15 : mcnt[ln] + 1;
          if (c >= int'(thresh_i)) begin etype = 2; mv[ln] = 0; mdel[ln] = 1; end
          else begin etype = 1; mcnt[ln] = c; mmask[ln] = '0; end
        end else begin
          eev = 1; mv[ln] = 0; mdel[ln] = 1;
          if (md[ln]) begin epois = 1; etype = 3; end
          else begin emiss = 1; etype = 2; end
        end
      end
    end
    if (eok) begin
      ln = as * WAYS + eway;
      mv[ln] = 1; md[ln] = adirty; mcnt[ln] = 0; mmask[ln] = af; mdat[ln] = ad;
      if (evic) mptr[as] = (eway + 1) % WAYS;
    end
    @(posedge clk_i); @(negedge clk_i);
    check(tag, "resp_valid", rd_resp_valid_o, rv);
    check(tag, "ev_valid", ev_valid_o, eev);
    if (rv) begin
      check(tag, "miss", rd_miss_o, emiss);
      check(tag, "poison", rd_poison_o, epois);
      if (ehit) check(tag, "data", rd_data_o, edat);
      if (eev) begin
        check(tag, "ev_type", ev_type_o, etype);
        check(tag, "ev_set", ev_set_o, rs);
        check(tag, "ev_way", ev_way_o, rw);
      end
    end
  endtask

  task automatic rd(string tag, int s, int w, logic [CW-1:0] f);
    step(tag, 1, s, w, f, 0, 0, '0, 0, '0);
  endtask
  task automatic al(string tag, int s, logic [DW-1:0] d, bit dirty, logic [CW-1:0] f);
    step(tag, 0, 0, 0, '0, 1, s, d, dirty, f);
  endtask
  function automatic logic [CW-1:0] b1(int n); return CW'(1) << n; endfunction
  function automatic logic [CW-1:0] b2(int n, int m); return (CW'(1) << n) | (CW'(1) << m); endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      mv[i] = 0; md[i] = 0; mdel[i] = 0; mcnt[i] = 0; mmask[i] = '0; mdat[i] = '0;
    end
    for (int s = 0; s < SETS; s++) mptr[s] = 0;
    repeat (3) @(negedge clk_i);
    check("R1", "resp_valid in reset", rd_resp_valid_o, 0);
    check("R1", "ev_valid in reset", ev_valid_o, 0);
    rst_ni = 1'b1;
    step("R1", 0, 0, 0, '0, 0, 0, '0, 0, '0);
    // R1/R7 fill set 0 in way order
    for (int w = 0; w < WAYS; w++) al("R1", 0, 32'hA5A50000 + w, 0, '0);
    for (int w = 0; w < WAYS; w++) rd("R10", 0, w, '0);
    // R2, R4: three corrections on set0 way1, third retires at threshold 3
    rd("R2", 0, 1, b1(5));
    rd("R2", 0, 1, b1(0));
    rd("R4", 0, 1, b1(CW-1));
    rd("R10", 0, 1, '0);
    // R7: victim skips the deleted way
    al("R7", 0, 32'h11112222, 0, '0);
    al("R7", 0, 32'h33334444, 0, '0);
    al("R7", 0, 32'h55556666, 0, '0);
    // R3: stored fault corrected once, then written back
    al("R3", 2, 32'hDEADBEEF, 1, b1(13));
    rd("R3", 2, 0, '0);
    rd("R3", 2, 0, '0);
    // R5: uncorrectable on clean line
    al("R5", 2, 32'h0F0F0F0F, 0, '0);
    rd("R5", 2, 1, b2(3, 30));
    rd("R10", 2, 1, '0);
    rd("R10", 2, 3, '0);
    // R6: uncorrectable on dirty line
    rd("R6", 2, 0, b2(1, 2));
    // R8: delete every way of set 1
    for (int w = 0; w < WAYS; w++) al("R8", 1, 32'h12340000 + w, w[0], '0);
    for (int w = 0; w < WAYS; w++) rd("R8", 1, w, b2(w + 4, w + 20));
    al("R8", 1, 32'hCAFEF00D, 0, '0);
    // R9: reallocation clears the count
    for (int w = 0; w < WAYS; w++) al("R9", 3, 32'h77770000 + w, 0, '0);
    rd("R9", 3, 0, b1(8));
    rd("R9", 3, 0, b1(9));
    al("R9", 3, 32'h89ABCDEF, 0, '0);
    rd("R9", 3, 0, b1(10));
    rd("R9", 3, 0, b1(11));
    // R4: lowered threshold retires on first correction
    thresh_i = 4'd1;
    rd("R4", 3, 1, b1(20));
    rd("R10", 3, 1, '0);
    // R11: read and allocate in the same cycle on different sets
    step("R11", 1, 3, 2, b1(6), 1, 2, 32'h24682468, 0, '0);
    step("R11", 0, 0, 0, '0, 0, 0, '0, 0, '0);
    rd("R11", 2, 2, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule